// File: doc/BRIEF.md
# Multi-Mode Parallel-to-Serial Line Converter

This block turns parallel words into one serial bit stream for an optical-line transmitter. Three word modes exist. At the lower line rate the word is either a 4-bit nibble or an 8-bit byte, chosen by `nib_sel`. At the higher line rate the word is always a full byte. Bit 7 of `par_word` is the first input bit and is sent first. The serial rate is four times the word rate in nibble mode and eight times the word rate in both byte modes.

Two clocks drive the block, and both are plain inputs. On each rising edge of the parallel clock `clk_par`, the block captures the word together with its effective mode into retime flops. A two-stage transfer then carries the word into the bit-clock domain with no handshake. This assumes `clk_par` is frequency-locked to `sub_clk`, and that the load strobe falls at least two bit clocks after the retime edge. A bit counter drives the load strobe. Its modulus is 4 or 8 and depends on the mode of the word now shifting. The shift register reloads in the same cycle that the last bit of the previous word goes out, so no gap bits appear between words.

A width state machine has two states. `ST_WIDE` shifts 8 bits and `ST_NARROW` shifts 4. The machine changes state only on the load strobe. Transition WIDE→NARROW is taken when the loaded word was captured in nibble mode. Transition NARROW→WIDE is taken when the loaded word was captured in a byte mode. All other cycles hold the state. Reset puts the machine in `ST_WIDE`. The block also produces a subrate clock `sub_clk`, which is the bit clock divided by the current word length. Upstream logic can source `clk_par` from it.

Top module: `serializer_tx`

## Requirements
- R1: While `rst` is high, `ser_out` is 0. After reset the first word shifted out is all zeros, so `ser_out` stays 0 until the first captured word begins.
- R2: With `rate_hi`=0 and `nib_sel`=0, each word sends 8 bits in the order `par_word[7]`, `par_word[6]`, down to `par_word[0]`.
- R3: With `rate_hi`=0 and `nib_sel`=1, each word sends 4 bits: `par_word[7]` first, then bit 6, bit 5 and `par_word[4]`. Bits 3..0 are ignored.
- R4: With `rate_hi`=1, each word sends 8 bits MSB first, and `nib_sel` has no effect.
- R5: Consecutive words follow each other with no gap. The first bit of a word comes in the bit-clock cycle right after the last bit of the previous word.
- R6: `sub_clk` rises on the bit-clock edge that presents the first bit of a word. It stays high for the first half of that word's bits and low for the second half, so its period is 4 or 8 bit clocks.
- R7: The mode pins are sampled together with the word on the rising edge of `clk_par`. A mode change applies from the word captured with it onward, and never inside a word.
- R8: Only the values of `par_word`, `rate_hi` and `nib_sel` at the rising edge of `clk_par` matter. Changes between those edges do not affect the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Bit-rate clock |
| clk_par | input | 1 | Parallel (retiming) clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_hi | input | 1 | 1 = high line rate (byte words only) |
| nib_sel | input | 1 | At low rate: 1 = nibble words, 0 = byte words |
| par_word | input | 8 | Parallel word; bit 7 is sent first |
| ser_out | output | 1 | Serial data |
| sub_clk | output | 1 | Bit clock divided by current word length |

## Verification
The bench streams words continuously and switches the mode from one word to the next. A design that applied a new mode to the word already in flight would send four bits where eight are due, or the reverse, and would misalign every bit after it. Between capture edges the bench drives inverted data and inverted mode pins. A design that sampled the pins anywhere except the `clk_par` rising edge, or that let the lower nibble leak into nibble mode, would show wrong bits at once. Each bit is also checked against the expected `sub_clk` level, so an off-by-one load strobe, a gap bit, or a wrong divider phase would fail.

// File: rtl/ser_pkg.sv
package ser_pkg;
    typedef enum logic [0:0] {
        ST_WIDE   = 1'b0,
        ST_NARROW = 1'b1
    } width_st_t;
endpackage

// File: rtl/ser_retime.sv
module ser_retime #(
    parameter int W = 8
) (
    input  logic         clk_par,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    input  logic         nib_in,
    output logic [W-1:0] d_q,
    output logic         nib_q
);
    always_ff @(posedge clk_par) begin
        if (rst) begin
            d_q   <= '0;
            nib_q <= 1'b0;
        end else begin
            d_q   <= d_in;
            nib_q <= nib_in;
        end
    end
endmodule

// File: rtl/ser_xfer.sv
module ser_xfer #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk_bit,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    input  logic         nib_in,
    output logic [W-1:0] d_out,
    output logic         nib_out
);
    logic [W-1:0] d_pipe   [STAGES];
    logic         nib_pipe [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk_bit) begin
                if (rst) begin
                    d_pipe[g]   <= '0;
                    nib_pipe[g] <= 1'b0;
                end else if (g == 0) begin
                    d_pipe[g]   <= d_in;
                    nib_pipe[g] <= nib_in;
                end else begin
                    d_pipe[g]   <= d_pipe[(g > 0) ? g-1 : 0];
                    nib_pipe[g] <= nib_pipe[(g > 0) ? g-1 : 0];
                end
            end
        end
    endgenerate

    assign d_out   = d_pipe[STAGES-1];
    assign nib_out = nib_pipe[STAGES-1];
endmodule

// File: rtl/ser_ctrl.sv
module ser_ctrl
    import ser_pkg::*;
#(
    parameter int W  = 8,
    parameter int NW = 4
) (
    input  logic clk_bit,
    input  logic rst,
    input  logic nib_word,
    output logic load,
    output logic sub_clk
);
    localparam int CW = $clog2(W);

    width_st_t     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_c;
    logic [CW:0]   half_c;
    logic [CW:0]   cnt_p1;
    logic          sub_q;

    // state register
    always_ff @(posedge clk_bit) begin
        if (rst) begin
            state_q <= ST_WIDE;
            cnt_q   <= '0;
            sub_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= load ? '0 : cnt_q + 1'b1;
            sub_q   <= load ? 1'b1 : (cnt_p1 < half_c);
        end
    end

    // next state: only at a word boundary
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WIDE:   if (load && nib_word)  state_d = ST_NARROW;
            ST_NARROW: if (load && !nib_word) state_d = ST_WIDE;
            default:   state_d = ST_WIDE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        unique case (state_q)
            ST_NARROW: begin
                last_c = CW'(NW - 1);
                half_c = (CW+1)'(NW / 2);
            end
            default: begin
                last_c = CW'(W - 1);
                half_c = (CW+1)'(W / 2);
            end
        endcase
        cnt_p1 = {1'b0, cnt_q} + 1'b1;
        load   = (cnt_q == last_c);
    end

    assign sub_clk = sub_q;

    AST_SUB_RISE_AT_LOAD: assert property (@(posedge clk_bit) disable iff (rst)
        $rose(sub_q) |-> $past(load)); // R6
    AST_WIDTH_HOLDS: assert property (@(posedge clk_bit) disable iff (rst)
        !load |=> $stable(state_q)); // R7
    AST_NARROW_RANGE: assert property (@(posedge clk_bit) disable iff (rst)
        (state_q == ST_NARROW) |-> (cnt_q < CW'(NW))); // R3
endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
    parameter int W = 8
) (
    input  logic         clk_bit,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] word,
    output logic         ser_out
);
    logic [W-1:0] sh_q;

    always_ff @(posedge clk_bit) begin
        if (rst)       sh_q <= '0;
        else if (load) sh_q <= word;
        else           sh_q <= {sh_q[W-2:0], 1'b0};
    end

    assign ser_out = sh_q[W-1];

    AST_QUIET_IN_RESET: assert property (@(posedge clk_bit)
        rst |=> (ser_out == 1'b0)); // R1
    AST_SHIFT_STEP: assert property (@(posedge clk_bit) disable iff (rst)
        !load |=> (ser_out == $past(sh_q[W-2]))); // R5
endmodule

// File: rtl/serializer_tx.sv
module serializer_tx #(
    parameter int W  = 8,
    parameter int NW = 4
) (
    input  logic         clk_bit,
    input  logic         clk_par,
    input  logic         rst,
    input  logic         rate_hi,
    input  logic         nib_sel,
    input  logic [W-1:0] par_word,
    output logic         ser_out,
    output logic         sub_clk
);
    logic         nib_eff;
    logic [W-1:0] ret_d, xf_d;
    logic         ret_nib, xf_nib;
    logic         load;

    // high rate forces byte words
    assign nib_eff = nib_sel & ~rate_hi;

    ser_retime #(.W(W)) u_retime (
        .clk_par (clk_par),
        .rst     (rst),
        .d_in    (par_word),
        .nib_in  (nib_eff),
        .d_q     (ret_d),
        .nib_q   (ret_nib)
    );

    ser_xfer #(.W(W), .STAGES(2)) u_xfer (
        .clk_bit (clk_bit),
        .rst     (rst),
        .d_in    (ret_d),
        .nib_in  (ret_nib),
        .d_out   (xf_d),
        .nib_out (xf_nib)
    );

    ser_ctrl #(.W(W), .NW(NW)) u_ctrl (
        .clk_bit  (clk_bit),
        .rst      (rst),
        .nib_word (xf_nib),
        .load     (load),
        .sub_clk  (sub_clk)
    );

    ser_shift #(.W(W)) u_shift (
        .clk_bit (clk_bit),
        .rst     (rst),
        .load    (load),
        .word    (xf_d),
        .ser_out (ser_out)
    );
endmodule

// File: tb/serializer_tx_test.sv
`timescale 1ns/1ps
module serializer_tx_test;
    typedef struct {
        logic  b;
        logic  s;
        string tag;
    } exp_t;

    logic       clk_bit = 1'b0;
    logic       rst     = 1'b1;
    logic       rate_hi = 1'b0;
    logic       nib_sel = 1'b0;
    logic [7:0] par_word = 8'h00;
    logic       clk_par;
    logic       ser_out, sub_clk;

    int   n_chk  = 0;
    int   n_fail = 0;
    bit   armed  = 1'b0;
    bit   first  = 1'b1;
    bit   done   = 1'b0;
    exp_t q[$];

    always #2.5 clk_bit = ~clk_bit;   // 200 MHz

    // parallel clock runs from the bit clock in reset, from the subrate clock after
    assign clk_par = rst ? clk_bit : sub_clk;

    serializer_tx uut (
        .clk_bit  (clk_bit),
        .clk_par  (clk_par),
        .rst      (rst),
        .rate_hi  (rate_hi),
        .nib_sel  (nib_sel),
        .par_word (par_word),
        .ser_out  (ser_out),
        .sub_clk  (sub_clk)
    );

    task automatic chk(input logic got, input logic exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: got=%0b expected=%0b", tag, $time, got, exp);
        end
    endtask

    // driver: one word per subrate period, garbage between capture edges
    task automatic send(input logic [7:0] w, input logic hi, input logic nib, input string tag);
        int m;
        @(negedge sub_clk);
        #1;
        par_word = w;
        rate_hi  = hi;
        nib_sel  = nib;
        m = (nib && !hi) ? 4 : 8;
        for (int i = 0; i < m; i++) begin
            exp_t e;
            e.b   = w[7-i];
            e.s   = (i < m/2);
            e.tag = tag;
            q.push_back(e);
        end
        if (first) begin
            first = 1'b0;
            fork
                begin
                    @(posedge sub_clk);
                    @(posedge sub_clk);
                    armed = 1'b1;
                end
            join_none
        end
        @(posedge sub_clk);
        #1;
        par_word = ~w ^ 8'h5A;   // R8: must not reach the output
        rate_hi  = ~hi;
        nib_sel  = ~nib;
    endtask

    // monitor / scoreboard
    always @(negedge clk_bit) begin
        if (!done) begin
            if (rst || !armed) begin
                chk(ser_out, 1'b0, "R1 quiet");
            end else if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(ser_out, e.b, e.tag);
                chk(sub_clk, e.s, "R6 subrate phase");
            end
        end
    end

    initial begin
        repeat (5) @(negedge clk_bit);
        rst = 1'b0;
        // R2: low-rate byte words, R5 back to back
        send(8'hA5, 1'b0, 1'b0, "R2 R5 R8");
        send(8'h81, 1'b0, 1'b0, "R2 R5 R8");
        send(8'hFF, 1'b0, 1'b0, "R2 R5");
        send(8'h00, 1'b0, 1'b0, "R2 R5");
        send(8'h3C, 1'b0, 1'b0, "R2 R8");
        // R3: nibble words, lower bits set to catch leakage
        send(8'hAF, 1'b0, 1'b1, "R3 R7");
        send(8'h5F, 1'b0, 1'b1, "R3 R5");
        send(8'h90, 1'b0, 1'b1, "R3 R8");
        send(8'h6F, 1'b0, 1'b1, "R3 R5");
        // R4: high rate ignores nib_sel
        send(8'hC3, 1'b1, 1'b1, "R4 R7");
        send(8'h7E, 1'b1, 1'b1, "R4 R8");
        send(8'h12, 1'b1, 1'b0, "R4 R5");
        // R7: mode alternating word by word
        for (int k = 0; k < 8; k++) begin
            send(8'h96 ^ 8'(k * 37), 1'b0, k[0], "R7 R5");
        end
        send(8'hE1, 1'b1, 1'b0, "R7 R4");
        send(8'hB4, 1'b0, 1'b1, "R7 R3");
        send(8'h4D, 1'b1, 1'b1, "R7 R4");
        send(8'h2B, 1'b0, 1'b0, "R7 R2");
        while (q.size() > 0) @(negedge clk_bit);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, got=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule